// File: doc/BRIEF.md
# Clock output enable gating

This block decides, for each of eight differential clock outputs and one single-ended reference output, whether the output carries the running clock or sits in a stop state. Several conditions feed the decision for a differential output: a configuration enable bit, an external enable pin whose active level is chosen per output, the global power-good level and a PLL lock indication. All of them must allow the output before it runs. When an output is not running, its true/complement pair is driven to one of four stop patterns, or released to high impedance, according to a shared 2-bit code.

The reference output has its own configuration enable. It ignores PLL lock. It stays released (undriven) until power-good has been seen high once after reset. After that, while power-good is low, it keeps running only when its wake bit is set. Enable requests are resynchronised into the clock domain of the output they control, and the gate opens and closes only at phase points where the affected wire is already low. As a result, no output ever carries a shortened pulse. High impedance is signalled by a per-output drive-enable bit rather than by z values.

Top module: `ckgate_top`

## Requirements
- R1: A differential output whose configuration enable bit (`regOe`) is 0 is stopped, whatever its pin, power-good and lock inputs are.
- R2: A stopped pair follows `stopCode`: 00 drives true low and complement low; 01 drops `clkDrive` to 0; 10 drives true high and complement low; 11 drives true low and complement high. True and complement are never high together.
- R3: Output i is enabled by its pin only when `oePin[i]` equals `oePol[i]`. With polarity 0 the pin enables when low, and with polarity 1 it enables when high. On a mismatch the output is stopped.
- R4: While `pllLock` is low, all differential outputs are stopped.
- R5: While `pwrGood` is low, all differential outputs are stopped.
- R6: After the combined enable of an output changes, the output starts or stops within 3 output-clock cycles. A running output drives true = `outClk` and complement = its inverse. Starting and stopping never produce a high pulse shorter than half a clock period.
- R7: Until `pwrGood` has been high at least once since reset, `refDrive` is 0.
- R8: Once `pwrGood` has been seen high, with `pwrGood` high the reference runs (`refOut` = `refClk`) exactly when `refOe` is 1. Otherwise it takes the true-side stop level of `stopCode`: high for 10, low for 00 and 11, and released for 01.
- R9: Once `pwrGood` has been seen high, with `pwrGood` low the reference runs only if both `refOe` and `refWake` are 1. Otherwise it is in the stop state of R8.
- R10: The reference output does not depend on `pllLock`.
- R11: During reset every gate is closed. All pairs show the stop state of the current code, and the reference is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| outClk | input | 1 | Output clock from the PLL, shared by all differential outputs |
| refClk | input | 1 | Reference clock from the crystal oscillator |
| rstN | input | 1 | Asynchronous active-low reset |
| regOe | input | 8 | Per-output configuration enable bits |
| oePin | input | 8 | Per-output enable pins (asynchronous) |
| oePol | input | 8 | Per-output pin polarity: 0 enables on low, 1 enables on high |
| pwrGood | input | 1 | Power-good level; low means powered down |
| pllLock | input | 1 | PLL lock indication |
| refOe | input | 1 | Reference configuration enable |
| refWake | input | 1 | Keep the reference running while powered down |
| stopCode | input | 2 | Stop-state code shared by all outputs |
| clkTrue | output | 8 | True side of each differential output |
| clkComp | output | 8 | Complement side of each differential output |
| clkDrive | output | 8 | Per-pair drive enable; 0 means high impedance |
| refOut | output | 1 | Reference output level |
| refDrive | output | 1 | Reference drive enable; 0 means high impedance |

## Verification
The assertions hold on every cycle. They check that an output held disabled for four cycles by its enable bit, its pin polarity, missing lock or missing power-good is released under code 01. They also check that true and complement never overlap high, and that the reference never drives before power-good has appeared. The exact stop levels for each code, the running waveform in both clock phases, the reference wake decision and the 3-cycle start and stop latency free of short pulses are shown only by the bench. It covers them with an exhaustive sweep of codes, enable combinations per lane and global states, plus a timed toggle test.

// File: rtl/ckgate_pkg.sv
package ckgate_pkg;

  typedef enum logic [1:0] {
    STOP_BOTH_LOW  = 2'b00,
    STOP_FLOAT     = 2'b01,
    STOP_TRUE_HIGH = 2'b10,
    STOP_COMP_HIGH = 2'b11
  } stopCode_e;

  // strobes from the decision logic to the reference gate
  typedef struct packed {
    logic refRun;
    logic refFloat;
  } refStrobe_t;

  function automatic logic stopTrueLevel(stopCode_e code);
    return code == STOP_TRUE_HIGH;
  endfunction

  function automatic logic stopCompLevel(stopCode_e code);
    return code == STOP_COMP_HIGH;
  endfunction

  function automatic logic stopDrives(stopCode_e code);
    return code != STOP_FLOAT;
  endfunction

endpackage

// File: rtl/ckgate_lane.sv
// One gate: resynchronises a run request and opens the true side on the
// falling edge and the complement side on the following rising edge, so
// each side is switched while it is low.
module ckgate_lane #(
  parameter int SYNC_STAGES = 2
) (
  input  logic laneClk,
  input  logic rstN,
  input  logic runReq,
  output logic gateTrue,
  output logic gateComp
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;

  always_ff @(posedge laneClk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], runReq};
  end

  always_ff @(negedge laneClk or negedge rstN) begin
    if (!rstN) gateTrue <= 1'b0;
    else       gateTrue <= syncQ[LAST];
  end

  always_ff @(posedge laneClk or negedge rstN) begin
    if (!rstN) gateComp <= 1'b0;
    else       gateComp <= gateTrue;
  end

endmodule

// File: rtl/ckgate_ctrl.sv
// Enable decision for all lanes and the reference wake logic.
module ckgate_ctrl
  import ckgate_pkg::*;
#(
  parameter int N           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         refClk,
  input  logic         rstN,
  input  logic [N-1:0] regOe,
  input  logic [N-1:0] oePin,
  input  logic [N-1:0] oePol,
  input  logic         pwrGood,
  input  logic         pllLock,
  input  logic         refOe,
  input  logic         refWake,
  output logic [N-1:0] laneRun,
  output refStrobe_t   refCtl
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] pgSyncQ;
  logic                   pgSeenQ;
  logic                   lanesAllowed;
  logic [N-1:0]           pinEnable;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      pgSyncQ <= '0;
      pgSeenQ <= 1'b0;
    end else begin
      pgSyncQ <= {pgSyncQ[SYNC_STAGES-2:0], pwrGood};
      pgSeenQ <= pgSeenQ | pgSyncQ[LAST];
    end
  end

  assign lanesAllowed = pwrGood & pllLock;
  assign pinEnable    = ~(oePin ^ oePol);
  assign laneRun      = regOe & pinEnable & {N{lanesAllowed}};

  always_comb begin
    refCtl.refFloat = ~pgSeenQ;
    refCtl.refRun   = pgSeenQ & refOe & (pwrGood | refWake);
  end

endmodule

// File: rtl/ckgate_path.sv
// Gates and output formatting for the differential lanes and the reference.
module ckgate_path
  import ckgate_pkg::*;
#(
  parameter int N           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         outClk,
  input  logic         refClk,
  input  logic         rstN,
  input  logic [N-1:0] laneRun,
  input  refStrobe_t   refCtl,
  input  stopCode_e    stopCode,
  output logic [N-1:0] clkTrue,
  output logic [N-1:0] clkComp,
  output logic [N-1:0] clkDrive,
  output logic         refOut,
  output logic         refDrive
);

  logic [N-1:0] gTrue;
  logic [N-1:0] gComp;
  logic         refGateT;
  logic         refGateC;
  logic         stopT;
  logic         stopC;
  logic         stopD;

  assign stopT = stopTrueLevel(stopCode);
  assign stopC = stopCompLevel(stopCode);
  assign stopD = stopDrives(stopCode);

  for (genvar g = 0; g < N; g++) begin : gen_lane
    ckgate_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
      .laneClk (outClk),
      .rstN    (rstN),
      .runReq  (laneRun[g]),
      .gateTrue(gTrue[g]),
      .gateComp(gComp[g])
    );
    // a half-open gate holds the other side low so the two never overlap
    assign clkTrue[g]  = gTrue[g] ? outClk  : (gComp[g] ? 1'b0 : stopT);
    assign clkComp[g]  = gComp[g] ? ~outClk : (gTrue[g] ? 1'b0 : stopC);
    assign clkDrive[g] = gTrue[g] | gComp[g] | stopD;
  end

  ckgate_lane #(.SYNC_STAGES(SYNC_STAGES)) u_refLane (
    .laneClk (refClk),
    .rstN    (rstN),
    .runReq  (refCtl.refRun),
    .gateTrue(refGateT),
    .gateComp(refGateC)
  );

  assign refOut   = refGateT ? refClk : (refGateC ? 1'b0 : stopT);
  assign refDrive = refGateT | refGateC | (stopD & ~refCtl.refFloat);

endmodule

// File: rtl/ckgate_top.sv
module ckgate_top
  import ckgate_pkg::*;
#(
  parameter int N           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         outClk,
  input  logic         refClk,
  input  logic         rstN,
  input  logic [N-1:0] regOe,
  input  logic [N-1:0] oePin,
  input  logic [N-1:0] oePol,
  input  logic         pwrGood,
  input  logic         pllLock,
  input  logic         refOe,
  input  logic         refWake,
  input  logic [1:0]   stopCode,
  output logic [N-1:0] clkTrue,
  output logic [N-1:0] clkComp,
  output logic [N-1:0] clkDrive,
  output logic         refOut,
  output logic         refDrive
);

  logic [N-1:0] laneRun;
  refStrobe_t   refCtl;

  ckgate_ctrl #(.N(N), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .refClk (refClk),
    .rstN   (rstN),
    .regOe  (regOe),
    .oePin  (oePin),
    .oePol  (oePol),
    .pwrGood(pwrGood),
    .pllLock(pllLock),
    .refOe  (refOe),
    .refWake(refWake),
    .laneRun(laneRun),
    .refCtl (refCtl)
  );

  ckgate_path #(.N(N), .SYNC_STAGES(SYNC_STAGES)) u_path (
    .outClk  (outClk),
    .refClk  (refClk),
    .rstN    (rstN),
    .laneRun (laneRun),
    .refCtl  (refCtl),
    .stopCode(stopCode_e'(stopCode)),
    .clkTrue (clkTrue),
    .clkComp (clkComp),
    .clkDrive(clkDrive),
    .refOut  (refOut),
    .refDrive(refDrive)
  );

endmodule

// File: rtl/ckgate_chk.sv
module ckgate_chk #(
  parameter int N = 8
) (
  input logic         outClk,
  input logic         refClk,
  input logic         rstN,
  input logic [N-1:0] regOe,
  input logic [N-1:0] oePin,
  input logic [N-1:0] oePol,
  input logic         pwrGood,
  input logic         pllLock,
  input logic [1:0]   stopCode,
  input logic [N-1:0] clkTrue,
  input logic [N-1:0] clkComp,
  input logic [N-1:0] clkDrive,
  input logic         refDrive
);

  logic         pgSeenChk;
  logic [N-1:0] pinOff;

  assign pinOff = oePin ^ oePol;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)        pgSeenChk <= 1'b0;
    else if (pwrGood) pgSeenChk <= 1'b1;
  end

  AST_REG_OFF_RELEASED: assert property (@(posedge outClk) disable iff (!rstN)
    (stopCode == 2'b01) |->
      ((clkDrive & ~(regOe | $past(regOe) | $past(regOe, 2) | $past(regOe, 3))) == '0))
    else $error("disabled-by-register lane still driven"); // R1

  AST_PAIR_NO_OVERLAP: assert property (@(posedge outClk) disable iff (!rstN)
    (clkTrue & clkComp) == '0)
    else $error("true and complement high together"); // R2

  AST_PIN_OFF_RELEASED: assert property (@(posedge outClk) disable iff (!rstN)
    (stopCode == 2'b01) |->
      ((clkDrive & pinOff & $past(pinOff) & $past(pinOff, 2) & $past(pinOff, 3)) == '0))
    else $error("pin-disabled lane still driven"); // R3

  AST_NO_LOCK_RELEASED: assert property (@(posedge outClk) disable iff (!rstN)
    (stopCode == 2'b01 && !pllLock && !$past(pllLock) && !$past(pllLock, 2) && !$past(pllLock, 3))
      |-> (clkDrive == '0))
    else $error("lane driven without lock"); // R4

  AST_POWER_DOWN_RELEASED: assert property (@(posedge outClk) disable iff (!rstN)
    (stopCode == 2'b01 && !pwrGood && !$past(pwrGood) && !$past(pwrGood, 2) && !$past(pwrGood, 3))
      |-> (clkDrive == '0))
    else $error("lane driven while powered down"); // R5

  AST_REF_FLOAT_EARLY: assert property (@(posedge refClk) disable iff (!rstN)
    (!pgSeenChk && !pwrGood) |-> !refDrive)
    else $error("reference driven before power-good"); // R7

endmodule

bind ckgate_top ckgate_chk #(.N(N)) u_chk (.*);

// File: tb/ckgate_top_bench.sv
`timescale 1ns/1ps
module ckgate_top_bench;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rstN;
  logic [N-1:0] regOe, oePin, oePol;
  logic         pwrGood, pllLock, refOe, refWake;
  logic [1:0]   stopCode;
  logic [N-1:0] clkTrue, clkComp, clkDrive;
  logic         refOut, refDrive;

  int  total = 0;
  int  bad   = 0;
  bit  pgEver = 1'b0;
  bit  monitorOn = 1'b0;
  int  runts = 0;
  real tRise = 0.0;
  real cRise = 0.0;

  always #5 clk = ~clk;

  // the reference clock is tied to the output clock in this bench
  ckgate_top u_ckgate_top (
    .outClk(clk), .refClk(clk), .rstN(rstN),
    .regOe(regOe), .oePin(oePin), .oePol(oePol),
    .pwrGood(pwrGood), .pllLock(pllLock), .refOe(refOe), .refWake(refWake),
    .stopCode(stopCode),
    .clkTrue(clkTrue), .clkComp(clkComp), .clkDrive(clkDrive),
    .refOut(refOut), .refDrive(refDrive)
  );

  // short-pulse monitor on lane 0 (R6)
  always @(posedge clkTrue[0]) tRise = $realtime;
  always @(negedge clkTrue[0]) if (monitorOn && ($realtime - tRise) < 4.5) runts++;
  always @(posedge clkComp[0]) cRise = $realtime;
  always @(negedge clkComp[0]) if (monitorOn && ($realtime - cRise) < 4.5) runts++;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkOutputs(bit highPhase);
    logic [N-1:0] eT, eC, eD;
    logic run, rr;
    for (int i = 0; i < N; i++) begin
      run   = regOe[i] & (oePin[i] == oePol[i]) & pwrGood & pllLock;
      eT[i] = run ? highPhase  : (stopCode == 2'b10);
      eC[i] = run ? !highPhase : (stopCode == 2'b11);
      eD[i] = run | (stopCode != 2'b01);
    end
    chk("R1/R2/R3/R4/R5 drive", clkDrive, eD);
    chk("R1/R2/R3/R4/R5 true", clkTrue & eD, eT & eD);
    chk("R1/R2/R3/R4/R5 comp", clkComp & eD, eC & eD);
    if (!pgEver) begin
      chk("R7 ref released", refDrive, 0);
    end else begin
      rr = refOe & (pwrGood | refWake);
      chk("R8/R9/R10 ref drive", refDrive, rr | (stopCode != 2'b01));
      if (rr | (stopCode != 2'b01))
        chk("R8/R9/R10 ref level", refOut, rr ? highPhase : (stopCode == 2'b10));
    end
  endtask

  task automatic settleAndCheck();
    repeat (6) @(posedge clk);
    @(negedge clk); #2;
    checkOutputs(1'b0);
    @(posedge clk); #2;
    checkOutputs(1'b1);
    @(negedge clk); #2;
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int n;
    logic [2:0] c;
    rstN = 1'b0; regOe = '0; oePin = '0; oePol = '0;
    pwrGood = 1'b0; pllLock = 1'b0; refOe = 1'b1; refWake = 1'b1; stopCode = 2'b00;
    #22;
    // R11: reset state with code 00
    chk("R11 true in reset", clkTrue, 0);
    chk("R11 comp in reset", clkComp, 0);
    chk("R11 drive in reset", clkDrive, {N{1'b1}});
    chk("R11 ref released in reset", refDrive, 0);
    rstN = 1'b1;
    regOe = '1; pllLock = 1'b1;

    // R7: before power-good the reference stays released for every setting
    for (int k = 0; k < 16; k++) begin
      stopCode = k[1:0]; refOe = k[2]; refWake = k[3];
      settleAndCheck();
    end

    pwrGood = 1'b1; pgEver = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk); #2;

    // exhaustive sweep: lane combos, codes, power-good, lock, reference bits
    for (int sh = 0; sh < 2; sh++) begin
      for (int k = 0; k < 64; k++) begin
        for (int i = 0; i < N; i++) begin
          c = 3'((i + sh * 3) % 8);
          regOe[i] = c[0]; oePin[i] = c[1]; oePol[i] = c[2];
        end
        stopCode = k[1:0]; pwrGood = k[2]; pllLock = k[3];
        refOe = k[4]; refWake = k[5];
        settleAndCheck();
      end
    end

    // R6: latency and short-pulse check on lane 0 with code 00
    stopCode = 2'b00; pwrGood = 1'b1; pllLock = 1'b1;
    regOe = '1; oePin = '0; oePol = '0;
    repeat (6) @(posedge clk);
    monitorOn = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(posedge clk); #(1 + k);
      regOe[0] = ~regOe[0];
      n = 0;
      for (int j = 1; j <= 6; j++) begin
        @(posedge clk); #2;
        if (n == 0 && clkTrue[0] == regOe[0]) n = j;
      end
      total++;
      if (n < 1 || n > 3) begin
        bad++;
        $display("FAIL R6 latency actual=%0d expected=1..3", n);
      end
    end
    monitorOn = 1'b0;
    chk("R6 no short pulses", runts, 0);

    finishRun();
  end

endmodule